// File: doc/BRIEF.md
# Single-Channel DMA Engine, Normal Transfer Mode

This block is one DMA channel that moves a fixed number of bytes or 16-bit words between two memory locations. Software uses a small register port to load a source address, a destination address, a transfer count and a control word. The control word selects the data size, how each address moves after a transfer, a channel enable and an interrupt enable. Each external transfer request then moves exactly one item. The item is read from the source address, held in an internal latch, and written to the destination address over a simple request/ready memory master port.

After every completed write, both addresses move by the transfer size (1 or 2) or stay where they are. The count drops by one. When the count reaches zero, the channel turns its own enable off and ignores further requests. If interrupts are enabled, it raises an interrupt line that stays high until software clears it. A count of zero loaded at the start means 65,536 transfers.

Top module: `dma_norm_chan`

## Requirements
- R1: After reset, all four registers read as zero, `irq_o` is low and `mem_req_o` is low.
- R2: Register writes read back unchanged. The registers are: index 0 source address (24 bits), index 1 destination address (24 bits), index 2 count (16 bits), and index 3 control. Control bit 0 is enable, bit 1 is interrupt enable, bit 2 is word size (0 = byte, 1 = word), bits 4:3 are the source step and bits 6:5 are the destination step. Control bit 7 reads back the interrupt flag.
- R3: One accepted request performs one read at the source address (`mem_we_o`=0), then one write (`mem_we_o`=1) at the destination address. The write carries the data that was read. In byte size the data is on bits 7:0.
- R4: In word size `mem_size_o` is 1, and all 16 data bits are moved.
- R5: After each transfer, each address steps independently. Step code 01 adds the size, code 10 subtracts the size, and codes 00 and 11 hold the address.
- R6: Address steps wrap modulo 2^24.
- R7: The count decreases by exactly one per completed transfer.
- R8: A transfer that moves the count from 1 to 0 clears the enable bit. Later requests start no memory access.
- R9: The expiring transfer sets `irq_o` only when the interrupt enable bit is 1.
- R10: A transfer that starts with a count of 0 leaves the count at 0xFFFF and keeps the channel enabled.
- R11: Requests that arrive while the channel is disabled or a transfer is in progress are dropped, not queued.
- R12: `irq_o` stays high until a control write that has bit 7 or bit 0 set.
- R13: An access with `mem_ready_i` low keeps its request, address and direction. Each access completes in the first cycle in which `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register index |
| cfg_wdata_i | input | 24 | Register write data |
| cfg_rdata_o | output | 24 | Register read data for `cfg_addr_i` |
| dreq_i | input | 1 | Transfer request |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write access, 0 = read access |
| mem_size_o | output | 1 | 1 = word access, 0 = byte access |
| mem_addr_o | output | 24 | Access address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid together with ready |
| mem_ready_i | input | 1 | Access completes in this cycle |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
The assertions assume that software does not write the address registers while an access is waiting for ready. Without that assumption, a held request could legally change its address. They also assume that the count and control registers are not written in the same cycle as a completing write. The bench meets both assumptions because every register write waits until the channel's write count shows the last transfer has finished. The memory model asserts ready only while a request is high, after a programmable number of wait cycles.

// File: rtl/dma_norm_pkg.sv
package dma_norm_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_KEEP = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } xfer_st_e;

  localparam logic [1:0] REG_SRC = 2'd0;
  localparam logic [1:0] REG_DST = 2'd1;
  localparam logic [1:0] REG_CNT = 2'd2;
  localparam logic [1:0] REG_CTL = 2'd3;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_norm_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic [AW-1:0] addr_i,
  input  step_e         mode_i,
  input  logic          word_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] delta;
  assign delta = word_i ? AW'(2) : AW'(1);

  always_comb begin
    case (mode_i)
      STEP_UP:   addr_o = addr_i + delta;
      STEP_DOWN: addr_o = addr_i - delta;
      default:   addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_norm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic req_o,
  output logic we_o,
  output logic capture_o,
  output logic done_o,
  output logic idle_o
);
  xfer_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_READ;
      ST_READ:  if (ready_i) st_d = ST_WRITE;
      ST_WRITE: if (ready_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign req_o     = !idle_o;
  assign we_o      = (st_q == ST_WRITE);
  assign capture_o = (st_q == ST_READ) && ready_i;
  assign done_o    = (st_q == ST_WRITE) && ready_i;
endmodule

// File: rtl/dma_norm_chan.sv
module dma_norm_chan
  import dma_norm_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] cfg_rdata_o,
  input  logic          dreq_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_size_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          irq_o
);
  localparam int unsigned CTL_W = 8;

  logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          en_q, ie_q, word_q, irq_q;
  step_e         smode_q, dmode_q;
  logic          start, capture, done, idle;
  logic [CTL_W-1:0] ctl_rd;

  dma_addr_step #(.AW(AW)) i_src_step (
    .addr_i(src_q), .mode_i(smode_q), .word_i(word_q), .addr_o(src_nx)
  );
  dma_addr_step #(.AW(AW)) i_dst_step (
    .addr_i(dst_q), .mode_i(dmode_q), .word_i(word_q), .addr_o(dst_nx)
  );

  assign start = dreq_i && en_q && idle;

  dma_xfer_fsm i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .ready_i  (mem_ready_i),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .capture_o(capture),
    .done_o   (done),
    .idle_o   (idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      word_q  <= 1'b0;
      irq_q   <= 1'b0;
      smode_q <= STEP_HOLD;
      dmode_q <= STEP_HOLD;
    end else begin
      if (capture) data_q <= mem_rdata_i;
      if (done) begin
        src_q <= src_nx;
        dst_q <= dst_nx;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          en_q <= 1'b0;
          if (ie_q) irq_q <= 1'b1;
        end
      end
      // software write takes precedence over a same-cycle update
      if (cfg_we_i) begin
        case (cfg_addr_i)
          REG_SRC: src_q <= cfg_wdata_i;
          REG_DST: dst_q <= cfg_wdata_i;
          REG_CNT: cnt_q <= cfg_wdata_i[CW-1:0];
          default: begin
            en_q    <= cfg_wdata_i[0];
            ie_q    <= cfg_wdata_i[1];
            word_q  <= cfg_wdata_i[2];
            smode_q <= step_e'(cfg_wdata_i[4:3]);
            dmode_q <= step_e'(cfg_wdata_i[6:5]);
            if (cfg_wdata_i[0] || cfg_wdata_i[7]) irq_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign ctl_rd = {irq_q, dmode_q, smode_q, word_q, ie_q, en_q};

  always_comb begin
    case (cfg_addr_i)
      REG_SRC: cfg_rdata_o = src_q;
      REG_DST: cfg_rdata_o = dst_q;
      REG_CNT: cfg_rdata_o = AW'(cnt_q);
      default: cfg_rdata_o = AW'(ctl_rd);
    endcase
  end

  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign mem_size_o  = word_q;
  assign mem_wdata_o = data_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/dma_norm_chan_chk.sv
module dma_norm_chan_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          en_q,
  input logic          ie_q,
  input logic [CW-1:0] cnt_q,
  input logic          irq_o
);
  logic wr_done;
  assign wr_done = mem_req_o && mem_we_o && mem_ready_i && !cfg_we_i;

  p_hold_access_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_count_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done |=> cnt_q == CW'($past(cnt_q) - CW'(1)));

  p_expire_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && cnt_q == CW'(1) |=> !en_q);

  p_wrap_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done && cnt_q == '0 && en_q |=> en_q);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ie_q);

  p_start_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(en_q) && !mem_we_o);
endmodule

bind dma_norm_chan dma_norm_chan_chk #(.AW(AW), .CW(CW)) i_chk (.*);

// File: tb/test_dma_norm_chan.sv
module test_dma_norm_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic        dreq = 1'b0;
  logic        mem_req, mem_we, mem_size, mem_ready;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  int wait_n = 0, wcnt = 0;
  int wr_cnt = 0, req_cycles = 0;
  logic [23:0] last_rd_addr = '0, rd_at_wr = '0;
  logic [7:0] mem [256];
  logic finished = 1'b0;

  always #10 clk = ~clk;

  dma_norm_chan i_dma_norm_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .dreq_i(dreq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .irq_o(irq)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  assign mem_rdata = {mem[8'(mem_addr + 24'd1)], mem[mem_addr[7:0]]};

  initial mem_ready = 1'b0;
  always @(negedge clk) begin
    if (mem_ready) begin mem_ready = 1'b0; wcnt = 0; end
    if (mem_req) begin
      if (wcnt >= wait_n) mem_ready = 1'b1;
      else wcnt++;
    end
  end

  always @(posedge clk) begin
    if (mem_req) req_cycles <= req_cycles + 1;
    if (mem_req && mem_ready && !mem_we) last_rd_addr <= mem_addr;
    if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_size) mem[8'(mem_addr + 24'd1)] <= mem_wdata[15:8];
      rd_at_wr <= last_rd_addr;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [23:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [23:0] e, input string rq);
    logic [23:0] v;
    cfg_rd(a, v);
    check(v == e, rq, 32'(v), 32'(e));
  endtask

  task automatic pulse_req();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic xfer_once();
    int w0 = wr_cnt;
    pulse_req();
    for (int i = 0; i < 200 && wr_cnt == w0; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg(2'd0, 24'h0, "R1 src");
    expect_reg(2'd1, 24'h0, "R1 dst");
    expect_reg(2'd2, 24'h0, "R1 cnt");
    expect_reg(2'd3, 24'h0, "R1 ctl");
    check(!irq && !mem_req, "R1 outputs", {irq, mem_req}, 0);
  endtask

  task automatic t_regs();
    cfg_wr(2'd0, 24'h123456); cfg_wr(2'd1, 24'hABCDEF);
    cfg_wr(2'd2, 24'h0005);   cfg_wr(2'd3, 24'h7E);
    expect_reg(2'd0, 24'h123456, "R2 src");
    expect_reg(2'd1, 24'hABCDEF, "R2 dst");
    expect_reg(2'd2, 24'h000005, "R2 cnt");
    expect_reg(2'd3, 24'h00007E, "R2 ctl");
  endtask

  task automatic t_byte();
    cfg_wr(2'd0, 24'h10); cfg_wr(2'd1, 24'h40); cfg_wr(2'd2, 24'd3);
    cfg_wr(2'd3, 24'h29);
    xfer_once();
    check(mem[8'h40] == pat(8'h10), "R3 byte data", mem[8'h40], pat(8'h10));
    check(rd_at_wr == 24'h10, "R3 read address", rd_at_wr, 24'h10);
    expect_reg(2'd0, 24'h11, "R5 src up");
    expect_reg(2'd1, 24'h41, "R5 dst up");
    expect_reg(2'd2, 24'd2, "R7 count");
    cfg_wr(2'd3, 24'h28);
  endtask

  task automatic t_word();
    cfg_wr(2'd0, 24'h20); cfg_wr(2'd1, 24'h80); cfg_wr(2'd2, 24'd2);
    cfg_wr(2'd3, 24'h15);
    xfer_once();
    check({mem[8'h81], mem[8'h80]} == {pat(8'h21), pat(8'h20)}, "R4 word data",
          {mem[8'h81], mem[8'h80]}, {pat(8'h21), pat(8'h20)});
    expect_reg(2'd0, 24'h1E, "R5 src down by 2");
    expect_reg(2'd1, 24'h80, "R5 dst fixed");
    cfg_wr(2'd3, 24'h14);
  endtask

  task automatic t_expire();
    int w0;
    cfg_wr(2'd0, 24'h30); cfg_wr(2'd1, 24'h50); cfg_wr(2'd2, 24'd2);
    cfg_wr(2'd3, 24'h2B);
    xfer_once();
    check(!irq, "R9 no irq before end", irq, 0);
    expect_reg(2'd3, 24'h2B, "R8 still enabled");
    xfer_once();
    check(irq, "R9 irq at end", irq, 1);
    expect_reg(2'd3, 24'hAA, "R8 enable cleared");
    expect_reg(2'd2, 24'd0, "R7 count at end");
    w0 = wr_cnt;
    pulse_req();
    repeat (10) @(negedge clk);
    check(wr_cnt == w0, "R8 request after end", wr_cnt, w0);
    expect_reg(2'd0, 24'h32, "R8 src unchanged");
    repeat (3) @(negedge clk);
    check(irq, "R12 irq held", irq, 1);
    cfg_wr(2'd3, 24'hAA);
    check(!irq, "R12 clear by bit7", irq, 0);
    cfg_wr(2'd2, 24'd1); cfg_wr(2'd3, 24'h2B);
    xfer_once();
    check(irq, "R9 irq again", irq, 1);
    cfg_wr(2'd2, 24'd1); cfg_wr(2'd3, 24'h2B);
    check(!irq, "R12 clear by enable", irq, 0);
    expect_reg(2'd3, 24'h2B, "R12 resumed enabled");
    cfg_wr(2'd3, 24'h28);
  endtask

  task automatic t_no_ie();
    cfg_wr(2'd0, 24'h60); cfg_wr(2'd1, 24'h70); cfg_wr(2'd2, 24'd1);
    cfg_wr(2'd3, 24'h29);
    xfer_once();
    check(!irq, "R9 irq masked", irq, 0);
    expect_reg(2'd3, 24'h28, "R8 enable cleared no ie");
  endtask

  task automatic t_wrap();
    cfg_wr(2'd0, 24'hFFFFFF); cfg_wr(2'd1, 24'h000001); cfg_wr(2'd2, 24'd0);
    cfg_wr(2'd3, 24'h49);
    xfer_once();
    expect_reg(2'd0, 24'h000000, "R6 src wraps up");
    expect_reg(2'd2, 24'hFFFF, "R10 count wraps");
    expect_reg(2'd3, 24'h49, "R10 still enabled");
    xfer_once();
    expect_reg(2'd1, 24'hFFFFFF, "R6 dst wraps down");
    expect_reg(2'd2, 24'hFFFE, "R10 continues");
    cfg_wr(2'd3, 24'h48);
  endtask

  task automatic t_ignore();
    int w0;
    cfg_wr(2'd0, 24'h90); cfg_wr(2'd1, 24'hA0); cfg_wr(2'd2, 24'd5);
    cfg_wr(2'd3, 24'h28);
    w0 = wr_cnt;
    pulse_req();
    repeat (10) @(negedge clk);
    check(wr_cnt == w0, "R11 disabled request", wr_cnt, w0);
    expect_reg(2'd2, 24'd5, "R11 disabled count");
    wait_n = 4;
    cfg_wr(2'd3, 24'h29);
    w0 = wr_cnt;
    req_cycles = 0;
    pulse_req();
    pulse_req();
    pulse_req();
    repeat (30) @(negedge clk);
    check(wr_cnt == w0 + 1, "R11 busy requests dropped", wr_cnt, w0 + 1);
    expect_reg(2'd2, 24'd4, "R11 busy count");
    check(req_cycles == 10, "R13 wait cycles", req_cycles, 10);
    check(mem[8'hA0] == pat(8'h90), "R13 data with waits", mem[8'hA0], pat(8'h90));
    wait_n = 0;
    cfg_wr(2'd3, 24'h28);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_byte();
    t_word();
    t_expire();
    t_no_ie();
    t_wrap();
    t_ignore();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule